// File: doc/BRIEF.md
# Multiplexed-Bus Control Register File

This block is the host-facing register store of a sound-generator peripheral. The host shares one 8-bit bus for both register addresses and data. Two control inputs tell the block what the bus carries in a given clock cycle: nothing, a register number to remember, a value to store, or a request to drive a value back. The block remembers the register number in an address latch. Every later store or fetch goes to that register until the host latches a new number.

All sixteen 8-bit registers are exported in parallel to the sound logic. Two of them also serve as general-purpose 8-bit ports. One control register holds a direction bit per port. When a port is set as an output, the port's register value drives its pins. When it is set as an input, a fetch of that register returns the live pin levels. The stored value is kept either way.

The data bus is modelled as a separate input, output and output enable. The output enable is high only while the host fetches data, so the pad sits at high impedance at all other times.

Top module: `mbus_regfile`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers and the address latch to zero. After reset, a store issued without a prior latch lands in register 0.
- R2: The control pair {ctl_dir, ctl_sel} is decoded as follows: 2'b00 is idle, 2'b01 is fetch, 2'b10 is store, and 2'b11 is latch address.
- R3: A latch-address cycle captures only bus bits [3:0] as the register number; bits [7:4] are ignored (latching 8'h35 selects register 5).
- R4: The latched register number holds until the next latch-address cycle, so several stores or fetches may follow a single latch.
- R5: A store cycle writes the bus value into the latched register at the clock edge and leaves the other fifteen registers unchanged.
- R6: During a fetch cycle bus_oe is 1 and bus_o carries the contents of the latched register in the same cycle. In idle, store and latch cycles bus_oe is 0.
- R7: Idle and fetch cycles change no register, whatever the bus carries.
- R8: Bit 6 of register 7 sets the direction of port 0, and bit 7 of register 7 sets the direction of port 1 (1 = output). port_oe[p] follows that bit, and port_o carries register 14 for port 0 (bits [7:0]) and register 15 for port 1 (bits [15:8]).
- R9: Fetching register 14 or 15 returns the port's pins (port_i bits [7:0] or [15:8]) when that port is an input, and returns the register value when it is an output.
- R10: A store to a port register is kept while the port is an input and appears on port_o once the port is switched to output. The store disturbs no other register.
- R11: regs_o exports register k on bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_dir | input | 1 | Bus control bit, upper of the function code |
| ctl_sel | input | 1 | Bus control bit, lower of the function code |
| bus_i | input | 8 | Shared address/data bus, inbound |
| bus_o | output | 8 | Shared bus, outbound fetch data |
| bus_oe | output | 1 | Bus output enable (0 = high impedance) |
| port_i | input | 16 | Sampled pins of port 1 (high byte) and port 0 (low byte) |
| port_o | output | 16 | Port output values, port 1 high byte |
| port_oe | output | 2 | Port output enables, one bit per port |
| regs_o | output | 128 | All sixteen registers, register k at bits [8k+7:8k] |

## Verification
The bench goes after the following corner cases:
- A store issued right after reset must land in register 0. A latch that failed to reset would scatter it elsewhere.
- A latch of 8'h35 must select register 5. A design that kept a wider address, or dropped the low bits, would write a different slot or none.
- Repeated stores and fetches after one latch must hit the same register. An implementation that cleared the latch after each access would fail here.
- For the ports, the bench flips each direction bit in turn. It checks that a fetch swaps between the pins and the stored byte, and that a byte stored while the port was an input reappears on the pins once the port becomes an output.
- Idle and fetch cycles with a busy bus must leave every register intact, and the enable must stay low on stores and latches. Otherwise the design would corrupt the array or fight the host on the bus.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [1:0] {
        FN_IDLE  = 2'b00,
        FN_READ  = 2'b01,
        FN_WRITE = 2'b10,
        FN_LATCH = 2'b11
    } bus_fn_e;
endpackage

// File: rtl/mbus_decode.sv
module mbus_decode
    import mbus_pkg::*;
(
    input  logic    ctl_dir,
    input  logic    ctl_sel,
    output bus_fn_e fn
);
    always_comb begin
        unique case ({ctl_dir, ctl_sel})
            2'b01:   fn = FN_READ;
            2'b10:   fn = FN_WRITE;
            2'b11:   fn = FN_LATCH;
            default: fn = FN_IDLE;
        endcase
    end
endmodule

// File: rtl/mbus_reg_array.sv
module mbus_reg_array
    import mbus_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bus_fn_e                    fn,
    input  logic [DATA_W-1:0]          bus_i,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]                  addr;
        logic [NUM_REGS-1:0][DATA_W-1:0]    regs;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (fn)
            FN_LATCH: st_d.addr = bus_i[ADDR_W-1:0];
            FN_WRITE: st_d.regs[st_q.addr] = bus_i;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign regs_o = st_q.regs;
endmodule

// File: rtl/mbus_port_ctrl.sv
module mbus_port_ctrl #(
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 16,
    parameter int NUM_PORTS = 2,
    parameter int PORT_BASE = 14,
    parameter int MODE_REG  = 7,
    parameter int MODE_BIT0 = 6
) (
    input  logic [NUM_REGS*DATA_W-1:0]  regs_i,
    input  logic [NUM_PORTS*DATA_W-1:0] pins_i,
    output logic [NUM_PORTS*DATA_W-1:0] port_o,
    output logic [NUM_PORTS-1:0]        port_oe,
    output logic [NUM_REGS*DATA_W-1:0]  view_o
);
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign port_oe[p] = regs_i[MODE_REG*DATA_W + MODE_BIT0 + p];
        assign port_o[p*DATA_W +: DATA_W] = regs_i[(PORT_BASE+p)*DATA_W +: DATA_W];
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_view
        if (r >= PORT_BASE && r < PORT_BASE + NUM_PORTS) begin : g_io
            assign view_o[r*DATA_W +: DATA_W] = port_oe[r-PORT_BASE]
                ? regs_i[r*DATA_W +: DATA_W]
                : pins_i[(r-PORT_BASE)*DATA_W +: DATA_W];
        end else begin : g_plain
            assign view_o[r*DATA_W +: DATA_W] = regs_i[r*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/mbus_read_mux.sv
module mbus_read_mux
    import mbus_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  bus_fn_e                    fn,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [NUM_REGS*DATA_W-1:0] view_i,
    output logic [DATA_W-1:0]          bus_o,
    output logic                       bus_oe
);
    logic [DATA_W-1:0] sel_d;

    always_comb begin
        sel_d = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (addr_i == ADDR_W'(r)) sel_d = view_i[r*DATA_W +: DATA_W];
        end
        bus_oe = (fn == FN_READ);
        bus_o  = bus_oe ? sel_d : '0;
    end
endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 16,
    parameter int NUM_PORTS = 2,
    parameter int PORT_BASE = 14,
    parameter int MODE_REG  = 7,
    parameter int MODE_BIT0 = 6,
    localparam int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ctl_dir,
    input  logic                       ctl_sel,
    input  logic [DATA_W-1:0]          bus_i,
    output logic [DATA_W-1:0]          bus_o,
    output logic                       bus_oe,
    input  logic [NUM_PORTS*DATA_W-1:0] port_i,
    output logic [NUM_PORTS*DATA_W-1:0] port_o,
    output logic [NUM_PORTS-1:0]       port_oe,
    output logic [NUM_REGS*DATA_W-1:0] regs_o
);
    bus_fn_e                    fn;
    logic [ADDR_W-1:0]          addr_q;
    logic [NUM_REGS*DATA_W-1:0] view;

    mbus_decode u_dec (
        .ctl_dir (ctl_dir),
        .ctl_sel (ctl_sel),
        .fn      (fn)
    );

    mbus_reg_array #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_arr (
        .clk    (clk),
        .rst    (rst),
        .fn     (fn),
        .bus_i  (bus_i),
        .addr_o (addr_q),
        .regs_o (regs_o)
    );

    mbus_port_ctrl #(
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .NUM_PORTS (NUM_PORTS),
        .PORT_BASE (PORT_BASE),
        .MODE_REG  (MODE_REG),
        .MODE_BIT0 (MODE_BIT0)
    ) u_ports (
        .regs_i  (regs_o),
        .pins_i  (port_i),
        .port_o  (port_o),
        .port_oe (port_oe),
        .view_o  (view)
    );

    mbus_read_mux #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_rd (
        .fn     (fn),
        .addr_i (addr_q),
        .view_i (view),
        .bus_o  (bus_o),
        .bus_oe (bus_oe)
    );
endmodule

// File: rtl/mbus_regfile_chk.sv
module mbus_regfile_chk #(
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 16,
    parameter int NUM_PORTS = 2,
    parameter int MODE_REG  = 7,
    parameter int MODE_BIT0 = 6,
    parameter int ADDR_W    = $clog2(NUM_REGS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       ctl_dir,
    input logic                       ctl_sel,
    input logic [DATA_W-1:0]          bus_i,
    input logic                       bus_oe,
    input logic [NUM_PORTS-1:0]       port_oe,
    input logic [ADDR_W-1:0]          addr_q,
    input logic [NUM_REGS*DATA_W-1:0] regs_o
);
    // R6: enable only in fetch cycles
    a_r6_oe_only_fetch: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!ctl_dir && ctl_sel));
    a_r6_oe_in_fetch: assert property (@(posedge clk) disable iff (rst)
        (!ctl_dir && ctl_sel) |-> bus_oe);
    // R3: latch captures the low bus bits
    a_r3_latch_capture: assert property (@(posedge clk) disable iff (rst)
        (ctl_dir && ctl_sel) |=> addr_q == $past(bus_i[ADDR_W-1:0]));
    // R4: latch holds outside latch cycles
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !(ctl_dir && ctl_sel) |=> $stable(addr_q));
    // R7: idle and fetch leave the array alone
    a_r7_no_change: assert property (@(posedge clk) disable iff (rst)
        !ctl_dir |=> $stable(regs_o));
    // R5: store lands in the latched register
    a_r5_write_lands: assert property (@(posedge clk) disable iff (rst)
        (ctl_dir && !ctl_sel) |=> regs_o[$past(addr_q)*DATA_W +: DATA_W] == $past(bus_i));
    // R8: direction bit of port 0 follows a store to the mode register
    a_r8_dir_follow: assert property (@(posedge clk) disable iff (rst)
        (ctl_dir && !ctl_sel && addr_q == ADDR_W'(MODE_REG))
        |=> port_oe[0] == $past(bus_i[MODE_BIT0]));
endmodule

bind mbus_regfile mbus_regfile_chk #(
    .DATA_W    (DATA_W),
    .NUM_REGS  (NUM_REGS),
    .NUM_PORTS (NUM_PORTS),
    .MODE_REG  (MODE_REG),
    .MODE_BIT0 (MODE_BIT0),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ctl_dir (ctl_dir),
    .ctl_sel (ctl_sel),
    .bus_i   (bus_i),
    .bus_oe  (bus_oe),
    .port_oe (port_oe),
    .addr_q  (addr_q),
    .regs_o  (regs_o)
);

// File: tb/mbus_regfile_test.sv
module mbus_regfile_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctl_dir = 1'b0, ctl_sel = 1'b0;
    logic [7:0]   bus_i = '0, bus_o;
    logic         bus_oe;
    logic [15:0]  port_i = '0, port_o;
    logic [1:0]   port_oe;
    logic [127:0] regs_o;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    mbus_regfile uut (
        .clk(clk), .rst(rst), .ctl_dir(ctl_dir), .ctl_sel(ctl_sel),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .port_i(port_i), .port_o(port_o), .port_oe(port_oe), .regs_o(regs_o)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_of(input int k);
        return regs_o[k*8 +: 8];
    endfunction

    function automatic logic [7:0] pat(input int k);
        return 8'(k * 17) ^ 8'hA5;
    endfunction

    task automatic drive(input logic d, input logic s, input logic [7:0] v);
        @(negedge clk);
        ctl_dir = d; ctl_sel = s; bus_i = v;
    endtask

    task automatic latch(input logic [7:0] a); drive(1'b1, 1'b1, a); endtask
    task automatic wr(input logic [7:0] v);    drive(1'b1, 1'b0, v); endtask
    task automatic idle();                      drive(1'b0, 1'b0, 8'h00); #1; endtask

    task automatic rd(input string tag, input logic [7:0] exp);
        drive(1'b0, 1'b1, 8'h00);
        #1;
        chk({tag, " oe"}, bus_oe, 1'b1);
        chk(tag, bus_o, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; ctl_dir = 0; ctl_sel = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 regs cleared", regs_o, '0);
        chk("R1 oe low", bus_oe, 1'b0);
        chk("R1 ports input", port_oe, 2'b00);
        wr(8'h5A);
        idle();
        chk("R1 latch zero after reset", reg_of(0), 8'h5A);
        rd("R1 fetch reg0", 8'h5A);
        do_reset();
        chk("R1 cleared again", regs_o, '0);
    endtask

    task automatic t_fill();
        logic [127:0] exp = '0;
        for (int k = 0; k < 16; k++) begin
            latch(8'(k)); wr(pat(k));
            exp[k*8 +: 8] = pat(k);
        end
        idle();
        chk("R11 export layout", regs_o, exp);
        chk("R6 oe low idle", bus_oe, 1'b0);
        for (int k = 0; k < 16; k++) begin
            latch(8'(k));
            rd("R6 fetch latched reg", pat(k));
        end
    endtask

    task automatic t_latch_bits();
        latch(8'h35); wr(8'h3C); idle();
        chk("R3 upper bits ignored", reg_of(5), 8'h3C);
        chk("R5 neighbour untouched", reg_of(3), pat(3));
    endtask

    task automatic t_multi();
        latch(8'h09); wr(8'h11); wr(8'h22); idle();
        chk("R4 second store same reg", reg_of(9), 8'h22);
        chk("R5 other reg unchanged", reg_of(10), pat(10));
        rd("R4 fetch 1", 8'h22);
        rd("R4 fetch 2", 8'h22);
        wr(8'h33); idle();
        chk("R4 store after fetch", reg_of(9), 8'h33);
    endtask

    task automatic t_ignore();
        logic [127:0] snap = regs_o;
        drive(1'b0, 1'b0, 8'hFF); drive(1'b0, 1'b0, 8'hAA); #1;
        chk("R6 oe low idle busy bus", bus_oe, 1'b0);
        rd("R7 fetch value", 8'h33);
        idle();
        chk("R7 array untouched", regs_o, snap);
        latch(8'h02); #1;
        chk("R6 oe low latch", bus_oe, 1'b0);
        wr(8'h44); #1;
        chk("R6 oe low store", bus_oe, 1'b0);
        idle();
        chk("R2 code 10 stores", reg_of(2), 8'h44);
        rd("R2 code 01 fetches", 8'h44);
    endtask

    task automatic t_ports();
        logic [127:0] exp = '0;
        do_reset();
        port_i = 16'h3CC3;
        latch(8'd14); wr(8'h99);
        rd("R9 port0 input pins", 8'hC3);
        chk("R8 port0 input", port_oe, 2'b00);
        latch(8'd15); wr(8'h66);
        rd("R9 port1 input pins", 8'h3C);
        latch(8'd7); wr(8'h40); idle();
        chk("R8 port0 output", port_oe, 2'b01);
        chk("R10 kept store on pins", port_o[7:0], 8'h99);
        latch(8'd14); rd("R9 port0 output reads reg", 8'h99);
        latch(8'd15); rd("R9 port1 still pins", 8'h3C);
        latch(8'd7); wr(8'h80); idle();
        chk("R8 port1 output", port_oe, 2'b10);
        chk("R8 port1 value", port_o[15:8], 8'h66);
        latch(8'd15); rd("R9 port1 output reads reg", 8'h66);
        latch(8'd14); rd("R9 port0 back to pins", 8'hC3);
        exp[7*8 +: 8] = 8'h80; exp[14*8 +: 8] = 8'h99; exp[15*8 +: 8] = 8'h66;
        chk("R10 no other reg disturbed", regs_o, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0d exp=0", 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_latch_bits();
        t_multi();
        t_ignore();
        t_ports();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule